// File: doc/BRIEF.md
# Sector Write-Protection Guard

This block sits in front of a serial flash's program and erase engine and rules on every request that would change the array. It answers each request with allow or deny in the same cycle. The ruling draws on three sources. The first is a per-sector protection register of one byte per sector. The second is a write-protect pin, together with a software protection switch. The third is a set of lockdown flags that can only ever be set.

The protection register has no direct write path. It changes only through keyed command frames, delivered as bytes while a frame is open. The first three key bytes are 3Dh, 2Ah and 7Fh. The fourth byte selects the action: CFh erases the register, FCh programs it from the eight bytes that follow, A9h turns software protection on, and 9Ah turns it off. The register must be erased before each program, and both actions are refused while the write-protect pin is high.

An error flag for the status register follows the result of each array operation and of each register program. A request that is denied for protection never changes this flag.

Top module: `spg_guard`

## Requirements
- R1: After reset every protection byte reads FFh and the register counts as erased. Software protection is off, no sector is locked and the error flag is 0.
- R2: A request for page p belongs to sector p[9:7]. While req_valid is high, exactly one of req_allow and req_deny is high in that same cycle. While req_valid is low, both are low.
- R3: A sector whose protection byte is nonzero is protected, and one whose byte is 00h is not. A protected sector is denied while wp is 1 or while software protection is on. Otherwise it is allowed.
- R4: The frame 3Dh 2Ah 7Fh A9h turns software protection on, and 3Dh 2Ah 7Fh 9Ah turns it off. sw_prot_on shows the state.
- R5: The frame 3Dh 2Ah 7Fh CFh sets every protection byte to FFh, marks the register erased and clears the error flag.
- R6: The frame 3Dh 2Ah 7Fh FCh followed by eight data bytes writes data byte i into sector i. The write happens only when the eighth data byte arrives. A frame that closes earlier leaves the register unchanged and still erased. Bytes after the eighth are ignored.
- R7: A program frame while the register is not erased leaves the register unchanged and sets the error flag to 1.
- R8: While wp is 1, erase and program frames leave both the register and the error flag unchanged.
- R9: A lock write ORs into the stored flags for lk_sector, and no input clears them. In sector 0, bits 7:6 = 11 lock pages 0-7 and bits 5:4 = 11 lock pages 8-127. In any other sector, either field at 11 locks the whole sector. A write with any of bits 3:0 set is ignored. A locked page is always denied.
- R10: op_done loads op_fail into the error flag. A denied request leaves the error flag unchanged.
- R11: A frame whose first three bytes differ from the key, or whose fourth byte is not one of the four action codes, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_active | input | 1 | Command frame open |
| byte_valid | input | 1 | byte_data holds a command byte |
| byte_data | input | 8 | Command byte |
| wp | input | 1 | Write-protect pin, active high |
| req_valid | input | 1 | Program or erase request present |
| req_page | input | 10 | Page targeted by the request |
| req_allow | output | 1 | Request may proceed |
| req_deny | output | 1 | Request refused |
| op_done | input | 1 | Array operation finished |
| op_fail | input | 1 | Finished operation failed |
| lk_valid | input | 1 | Lock write strobe |
| lk_sector | input | 3 | Sector of the lock write |
| lk_bits | input | 8 | Lock field byte |
| rd_sector | input | 3 | Sector whose protection byte is shown |
| rd_byte | output | 8 | Protection byte of rd_sector |
| sw_prot_on | output | 1 | Software protection on |
| err_flag | output | 1 | Program/erase error flag |

## Verification
The bench programs a byte of 01h to show that any nonzero byte protects. A design that tested only for FFh would allow that sector. It reprograms without an erase and expects the register to stay the same and the error flag to rise. It also cuts a program frame short and expects nothing to change, and a design that wrote each byte as it arrived would leave a partial register. Lock fields are probed at the 0a/0b page boundary (pages 7 and 8). A lock byte with a single bit of a field set must not lock, and a zero lock write must not unlock. Finally, a locked request is denied while the error flag is 1, and the flag must stay set.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int unsigned KEY_LEN = 4;
  localparam logic [7:0] KEY_B0 = 8'h3D;
  localparam logic [7:0] KEY_B1 = 8'h2A;
  localparam logic [7:0] KEY_B2 = 8'h7F;
  localparam logic [7:0] ACT_ERASE  = 8'hCF;
  localparam logic [7:0] ACT_PROG   = 8'hFC;
  localparam logic [7:0] ACT_SW_ON  = 8'hA9;
  localparam logic [7:0] ACT_SW_OFF = 8'h9A;

  // expected key byte for position idx (0..2)
  function automatic logic [7:0] key_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    key_byte = KEY_B0;
      2'd1:    key_byte = KEY_B1;
      default: key_byte = KEY_B2;
    endcase
  endfunction

  // a two-bit lock field is armed only when both bits are set
  function automatic logic field_armed(input logic [1:0] f);
    field_armed = (f == 2'b11);
  endfunction
endpackage

// File: rtl/spg_seq_decode.sv
module spg_seq_decode
  import spg_pkg::*;
#(
  parameter int unsigned NUM_SECT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_active,
  input  logic                     byte_valid,
  input  logic [7:0]               byte_data,
  output logic                     erase_evt,
  output logic                     prog_evt,
  output logic                     on_evt,
  output logic                     off_evt,
  output logic [NUM_SECT-1:0][7:0] prog_data
);
  localparam int unsigned LAST   = KEY_LEN + NUM_SECT;
  localparam int unsigned CNT_W  = $clog2(LAST + 1);
  localparam int unsigned SLOT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic [CNT_W-1:0]  cnt;
  logic              key_ok;
  logic              prog_mode;
  logic [SLOT_W-1:0] slot;

  assign slot = SLOT_W'(cnt - CNT_W'(KEY_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      key_ok    <= 1'b1;
      prog_mode <= 1'b0;
      erase_evt <= 1'b0;
      prog_evt  <= 1'b0;
      on_evt    <= 1'b0;
      off_evt   <= 1'b0;
      prog_data <= '0;
    end else begin
      erase_evt <= 1'b0;
      prog_evt  <= 1'b0;
      on_evt    <= 1'b0;
      off_evt   <= 1'b0;
      if (!frame_active) begin
        cnt       <= '0;
        key_ok    <= 1'b1;
        prog_mode <= 1'b0;
      end else if (byte_valid) begin
        if (cnt != CNT_W'(LAST)) cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(KEY_LEN - 1)) begin
          if (byte_data != key_byte(cnt[1:0])) key_ok <= 1'b0;
        end else if (cnt == CNT_W'(KEY_LEN - 1)) begin
          if (key_ok) begin
            case (byte_data)
              ACT_ERASE:  erase_evt <= 1'b1;
              ACT_PROG:   prog_mode <= 1'b1;
              ACT_SW_ON:  on_evt    <= 1'b1;
              ACT_SW_OFF: off_evt   <= 1'b1;
              default: ;
            endcase
          end
        end else if (prog_mode && cnt < CNT_W'(LAST)) begin
          prog_data[slot] <= byte_data;
          if (cnt == CNT_W'(LAST - 1)) prog_evt <= 1'b1;
        end
      end
    end
  end

  // R6 program commit never coincides with another action
  prog_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |-> !(erase_evt || on_evt || off_evt));
endmodule

// File: rtl/spg_prot_store.sv
module spg_prot_store #(
  parameter int unsigned NUM_SECT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wp,
  input  logic                     erase_evt,
  input  logic                     prog_evt,
  input  logic                     on_evt,
  input  logic                     off_evt,
  input  logic [NUM_SECT-1:0][7:0] prog_data,
  input  logic                     op_done,
  input  logic                     op_fail,
  output logic [NUM_SECT-1:0][7:0] spr,
  output logic                     sw_on,
  output logic                     erased,
  output logic                     err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spr    <= '1;
      erased <= 1'b1;
      sw_on  <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (on_evt)  sw_on <= 1'b1;
      if (off_evt) sw_on <= 1'b0;
      if (op_done) err <= op_fail;
      if (!wp) begin
        if (erase_evt) begin
          spr    <= '1;
          erased <= 1'b1;
          err    <= 1'b0;
        end else if (prog_evt) begin
          if (erased) begin
            spr    <= prog_data;
            erased <= 1'b0;
            err    <= 1'b0;
          end else begin
            err <= 1'b1;
          end
        end
      end
    end
  end

  // R8
  wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp && (erase_evt || prog_evt) && !op_done |=> $stable(spr) && $stable(err));

  // R7
  unerased_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt && !wp && !erased |=> $stable(spr) && err);

  // R5
  erase_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_evt && !wp |=> (spr == '1) && erased && !err);
endmodule

// File: rtl/spg_lock_store.sv
module spg_lock_store
  import spg_pkg::*;
#(
  parameter int unsigned NUM_SECT = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [SECT_W-1:0]        lk_sector,
  input  logic [7:0]               lk_bits,
  output logic [NUM_SECT-1:0][1:0] lock_f
);
  logic       lk_ok;
  logic [1:0] new_f;

  assign lk_ok = lk_valid && (lk_bits[3:0] == 4'h0);
  assign new_f = {field_armed(lk_bits[7:6]), field_armed(lk_bits[5:4])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_f <= '0;
    else if (lk_ok) lock_f[lk_sector] <= lock_f[lk_sector] | new_f;
  end

  // R9 a flag once set stays set
  lock_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_f & $past(lock_f)) == $past(lock_f)));
endmodule

// File: rtl/spg_decide.sv
module spg_decide #(
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned PAGE_W      = 10,
  parameter int unsigned SUB0A_PAGES = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                     req_valid,
  input  logic [PAGE_W-1:0]        req_page,
  input  logic [NUM_SECT-1:0][7:0] spr,
  input  logic [NUM_SECT-1:0][1:0] lock_f,
  input  logic                     sw_on,
  input  logic                     wp,
  output logic                     allow,
  output logic                     deny
);
  function automatic logic [SECT_W-1:0] sector_of(input logic [PAGE_W-1:0] p);
    sector_of = p[PAGE_W-1 -: SECT_W];
  endfunction

  // lock_f[s] = {field 7:6 armed, field 5:4 armed}
  function automatic logic page_locked(input logic [PAGE_W-1:0] p,
                                       input logic [1:0] f);
    if (sector_of(p) == '0)
      page_locked = (p < PAGE_W'(SUB0A_PAGES)) ? f[1] : f[0];
    else
      page_locked = f[1] | f[0];
  endfunction

  logic [SECT_W-1:0] sec;
  logic              locked;
  logic              guarded;

  assign sec     = sector_of(req_page);
  assign locked  = page_locked(req_page, lock_f[sec]);
  assign guarded = (spr[sec] != 8'h00) && (wp || sw_on);
  assign deny    = req_valid && (locked || guarded);
  assign allow   = req_valid && !(locked || guarded);
endmodule

// File: rtl/spg_guard.sv
module spg_guard #(
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned PAGE_W      = 10,
  parameter int unsigned SUB0A_PAGES = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              wp,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_allow,
  output logic              req_deny,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              lk_valid,
  input  logic [SECT_W-1:0] lk_sector,
  input  logic [7:0]        lk_bits,
  input  logic [SECT_W-1:0] rd_sector,
  output logic [7:0]        rd_byte,
  output logic              sw_prot_on,
  output logic              err_flag
);
  logic                     erase_evt, prog_evt, on_evt, off_evt;
  logic [NUM_SECT-1:0][7:0] prog_data;
  logic [NUM_SECT-1:0][7:0] spr;
  logic [NUM_SECT-1:0][1:0] lock_f;
  logic                     erased;

  spg_seq_decode #(.NUM_SECT(NUM_SECT)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .erase_evt(erase_evt), .prog_evt(prog_evt), .on_evt(on_evt),
    .off_evt(off_evt), .prog_data(prog_data));

  spg_prot_store #(.NUM_SECT(NUM_SECT)) u_store (
    .clk(clk), .rst_n(rst_n), .wp(wp), .erase_evt(erase_evt),
    .prog_evt(prog_evt), .on_evt(on_evt), .off_evt(off_evt),
    .prog_data(prog_data), .op_done(op_done), .op_fail(op_fail),
    .spr(spr), .sw_on(sw_prot_on), .erased(erased), .err(err_flag));

  spg_lock_store #(.NUM_SECT(NUM_SECT)) u_lock (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_sector(lk_sector),
    .lk_bits(lk_bits), .lock_f(lock_f));

  spg_decide #(.NUM_SECT(NUM_SECT), .PAGE_W(PAGE_W),
               .SUB0A_PAGES(SUB0A_PAGES)) u_dec_rule (
    .req_valid(req_valid), .req_page(req_page), .spr(spr), .lock_f(lock_f),
    .sw_on(sw_prot_on), .wp(wp), .allow(req_allow), .deny(req_deny));

  assign rd_byte = spr[rd_sector];

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({req_allow, req_deny}));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_allow && !req_deny);

  // R10
  deny_keeps_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_deny && !op_done && !erase_evt && !prog_evt |=> $stable(err_flag));

  // R4
  sw_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt && !off_evt |=> sw_prot_on);
endmodule

// File: tb/tb_spg_guard.sv
module tb_spg_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_active = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       wp = 1'b0, req_valid = 1'b0;
  logic [9:0] req_page = '0;
  logic       req_allow, req_deny;
  logic       op_done = 1'b0, op_fail = 1'b0;
  logic       lk_valid = 1'b0;
  logic [2:0] lk_sector = '0;
  logic [7:0] lk_bits = '0;
  logic [2:0] rd_sector = '0;
  logic [7:0] rd_byte;
  logic       sw_prot_on, err_flag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spg_guard dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tx(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic frame_open();
    @(negedge clk); frame_active = 1'b1;
  endtask

  task automatic frame_close();
    @(negedge clk); frame_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic key_cmd(input logic [7:0] b0, input logic [7:0] act);
    frame_open(); tx(b0); tx(8'h2A); tx(8'h7F); tx(act); frame_close();
  endtask

  // sends n data bytes; bytes beyond the eighth are 55h
  task automatic prog_cmd(input logic [63:0] d, input int n);
    frame_open(); tx(8'h3D); tx(8'h2A); tx(8'h7F); tx(8'hFC);
    for (int i = 0; i < n; i++) tx(i < 8 ? d[i*8 +: 8] : 8'h55);
    frame_close();
  endtask

  task automatic chk_spr(input string tag, input logic [63:0] d);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); rd_sector = 3'(s); #1;
      chk(tag, {24'h0, rd_byte}, {24'h0, d[s*8 +: 8]});
    end
  endtask

  task automatic chk_req(input string tag, input int page, input logic exp_deny);
    @(negedge clk); req_valid = 1'b1; req_page = 10'(page); #1;
    chk(tag, {30'h0, req_allow, req_deny}, {30'h0, !exp_deny, exp_deny});
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic lock_wr(input int sec, input logic [7:0] b);
    @(negedge clk); lk_valid = 1'b1; lk_sector = 3'(sec); lk_bits = b;
    @(negedge clk); lk_valid = 1'b0;
  endtask

  task automatic op_finish(input logic fail);
    @(negedge clk); op_done = 1'b1; op_fail = fail;
    @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
  endtask

  task automatic t_reset();
    chk_spr("R1 reset bytes", '1);
    chk("R1 sw off", {31'h0, sw_prot_on}, 0);
    chk("R1 err clear", {31'h0, err_flag}, 0);
    #1; chk("R2 idle quiet", {30'h0, req_allow, req_deny}, 0);
    chk_req("R1 R3 sw off allows", 300, 1'b0);
    chk_req("R1 R9 no lock", 3, 1'b0);
  endtask

  task automatic t_wp_guard();
    wp = 1'b1;
    chk_req("R3 wp denies FF", 300, 1'b1);
    wp = 1'b0;
  endtask

  task automatic t_program_and_sw();
    prog_cmd(64'h0000_0000_0100_FF00, 8);
    chk_spr("R6 program", 64'h0000_0000_0100_FF00);
    chk("R6 err 0", {31'h0, err_flag}, 0);
    chk_req("R3 sw off sector1", 200, 1'b0);
    key_cmd(8'h3D, 8'hA9);
    chk("R4 sw on", {31'h0, sw_prot_on}, 1);
    chk_req("R2 R3 sector1 FF", 200, 1'b1);
    chk_req("R3 sector3 01h", 400, 1'b1);
    chk_req("R3 sector2 00h", 300, 1'b0);
    chk_req("R2 sector0 00h", 5, 1'b0);
    key_cmd(8'h3D, 8'h9A);
    chk("R4 sw off", {31'h0, sw_prot_on}, 0);
    chk_req("R4 sector1 after off", 200, 1'b0);
  endtask

  task automatic t_unerased();
    prog_cmd('1, 8);
    chk_spr("R7 unchanged", 64'h0000_0000_0100_FF00);
    chk("R7 err set", {31'h0, err_flag}, 1);
    key_cmd(8'h3D, 8'hCF);
    chk_spr("R5 erased", '1);
    chk("R5 err cleared", {31'h0, err_flag}, 0);
  endtask

  task automatic t_short_and_extra();
    prog_cmd('0, 5);
    chk_spr("R6 short frame", '1);
    prog_cmd('0, 10);
    chk_spr("R6 extra bytes ignored", '0);
  endtask

  task automatic t_wp_freeze();
    op_finish(1'b1);
    wp = 1'b1;
    key_cmd(8'h3D, 8'hCF);
    chk_spr("R8 erase blocked", '0);
    chk("R8 err kept", {31'h0, err_flag}, 1);
    wp = 1'b0;
    op_finish(1'b0);
  endtask

  task automatic t_bad_key();
    key_cmd(8'h3C, 8'hCF);
    chk_spr("R11 bad key", '0);
    key_cmd(8'h3D, 8'hCE);
    chk_spr("R11 bad action", '0);
  endtask

  task automatic t_lock();
    lock_wr(0, 8'hC0);
    chk_req("R9 0a locked p7", 7, 1'b1);
    chk_req("R9 0b free p8", 8, 1'b0);
    lock_wr(0, 8'h30);
    chk_req("R9 0b locked p8", 8, 1'b1);
    lock_wr(5, 8'h40);
    chk_req("R9 half field", 641, 1'b0);
    lock_wr(5, 8'hC1);
    chk_req("R9 reserved bit", 641, 1'b0);
    lock_wr(5, 8'hC0);
    chk_req("R9 sector5 locked", 641, 1'b1);
    chk_req("R9 sector4 free", 520, 1'b0);
    lock_wr(5, 8'h00);
    chk_req("R9 one-way", 641, 1'b1);
  endtask

  task automatic t_err();
    op_finish(1'b1);
    chk("R10 fail loads", {31'h0, err_flag}, 1);
    chk_req("R10 locked deny", 641, 1'b1);
    repeat (2) @(negedge clk);
    chk("R10 deny keeps err", {31'h0, err_flag}, 1);
    op_finish(1'b0);
    chk("R10 ok clears", {31'h0, err_flag}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wp_guard();
    t_program_and_sw();
    t_unerased();
    t_short_and_extra();
    t_wp_freeze();
    t_bad_key();
    t_lock();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule